// File: doc/BRIEF.md
# Paged Local-Bus to PCI Express Address Translator

This block turns an address from a narrow local memory-mapped bus into a 64-bit PCI Express address. The local address space is cut into equal pages whose size is a power of two between 4 KB and 4 GB. The page-number bits at the top of each incoming address pick one entry of a page table. The translated address is that entry's bits above the page offset, followed by the request's own offset bits. The page count is a power of two from 1 to 512, and it equals the number of table entries.

The table has two build-time variants. In the software-loaded variant, each 64-bit entry sits in on-chip registers that clear to zero on reset. Software writes and reads each entry as two 32-bit words through a small control-register port. In the constant variant, the entries come from a parameter and nothing can change them at run time. This variant allows at most 16 pages. Its control port still reads the constants back, and it drops every write.

Top module: `pcie_addr_xlate`

## Requirements
- R1: `out_valid` is high in the cycle right after a cycle with `req_valid` high, and low after a cycle with `req_valid` low. Back-to-back requests each produce their own result, in order.
- R2: `out_addr[PAGE_BITS-1:0]` equals the request's `req_addr[PAGE_BITS-1:0]`.
- R3: The top `log2(PAGE_CNT)` bits of `req_addr` form the entry index. `out_addr[63:PAGE_BITS]` equals that entry's bits `[63:PAGE_BITS]`.
- R4: Entry bits below `PAGE_BITS` never reach `out_addr`. They are still stored and read back exactly as written.
- R5: The control port uses byte addresses. Entry n's bits 31:0 are at byte address 8n and its bits 63:32 are at 8n+4. Address bit 2 selects the word, bits above bit 2 give n, and bits 1:0 are ignored. A write replaces all 32 bits of the word.
- R6: A read pulse on `csr_rd` sets `csr_rvalid` high in the next cycle, with `csr_rdata` holding the word stored at that moment. A word written in one cycle reads back in any later cycle.
- R7: After reset, `out_valid` and `csr_rvalid` are low. Every software-loaded entry reads as zero and translates with zero upper bits.
- R8: A table write in the same cycle as a request does not change that request's result. The next request that uses the entry sees the new value.
- R9: With `DYNAMIC` = 0, entry n is `FIXED_TABLE[64n+63:64n]` and `PAGE_CNT` may not exceed 16. Control writes change neither the readback nor the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| req_valid | input | 1 | A local address is presented this cycle |
| req_addr | input | LOCAL_AW | Local bus byte address |
| out_valid | output | 1 | Translated address is valid |
| out_addr | output | 64 | Translated PCI Express address |
| csr_wr | input | 1 | Control-port write strobe |
| csr_rd | input | 1 | Control-port read strobe |
| csr_addr | input | CSR_AW | Control-port byte address |
| csr_wdata | input | 32 | Control-port write data |
| csr_rdata | output | 32 | Control-port read data, registered |
| csr_rvalid | output | 1 | Read data valid, one cycle after `csr_rd` |

## Verification
Translations use offsets of all zeros, all ones and mixed bits, at the first, the last and middle page indices. A swapped or shifted field then shows up as a wrong offset or a wrong entry. Each entry is loaded with a distinct high and low word, and control addresses with nonzero bits 1:0 are used, which separates a word-select or index-decode error from a storage error. A write that collides with a request in the same cycle separates registered lookup timing from a path that uses the new value too early. The constant-table instance receives writes and then must read back and translate exactly as before.

// File: rtl/pax_pkg.sv
package pax_pkg;

  localparam int ENTRY_W   = 64;
  localparam int WORD_W    = 32;
  localparam int MAX_FIXED = 16;

  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [WORD_W-1:0]  word_t;

  // index width with a floor of one bit so storage never has zero width
  function automatic int idx_width(input int pages);
    return (pages > 1) ? $clog2(pages) : 1;
  endfunction

  // number of local address bits that select a page
  function automatic int sel_width(input int pages);
    return (pages > 1) ? $clog2(pages) : 0;
  endfunction

endpackage

// File: rtl/pax_rst_sync.sv
module pax_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pax_table.sv
module pax_table import pax_pkg::*; #(
  parameter int PAGE_CNT = 8,
  parameter bit DYNAMIC  = 1'b1,
  parameter logic [MAX_FIXED*ENTRY_W-1:0] FIXED_TABLE = '0,
  localparam int IDX_W = idx_width(PAGE_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output entry_t           lk_entry,
  input  logic [IDX_W-1:0] cs_idx,
  input  logic             cs_hi,
  input  logic             wr_en,
  input  word_t            wr_data,
  output word_t            rd_word
);

  entry_t ent [PAGE_CNT];
  entry_t cs_entry;

  if (DYNAMIC) begin : g_dyn
    for (genvar g = 0; g < PAGE_CNT; g++) begin : g_ent
      entry_t ent_d;
      entry_t ent_q;
      logic   ent_en;

      always_comb begin
        ent_en = wr_en && (cs_idx == IDX_W'(g));
        ent_d  = ent_q;
        if (cs_hi) begin
          ent_d[ENTRY_W-1:WORD_W] = wr_data;
        end else begin
          ent_d[WORD_W-1:0] = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (ent_en) begin
          ent_q <= ent_d;
        end
      end

      assign ent[g] = ent_q;
    end
  end else begin : g_fix
    if (PAGE_CNT > MAX_FIXED) begin : g_limit
      $error("constant page table allows at most 16 pages");
    end
    for (genvar g = 0; g < PAGE_CNT; g++) begin : g_ent
      assign ent[g] = FIXED_TABLE[g*ENTRY_W +: ENTRY_W];
    end
    logic unused_fix;
    assign unused_fix = ^{clk, rst_n, wr_en, wr_data};
  end

  if (PAGE_CNT > 1) begin : g_multi
    assign lk_entry = ent[lk_idx];
    assign cs_entry = ent[cs_idx];
  end else begin : g_single
    assign lk_entry = ent[0];
    assign cs_entry = ent[0];
    logic unused_idx;
    assign unused_idx = ^{lk_idx, cs_idx};
  end

  always_comb begin
    rd_word = cs_hi ? cs_entry[ENTRY_W-1:WORD_W] : cs_entry[WORD_W-1:0];
  end

endmodule

// File: rtl/pax_csr.sv
module pax_csr import pax_pkg::*; #(
  parameter int PAGE_CNT = 8,
  localparam int IDX_W  = idx_width(PAGE_CNT),
  localparam int CSR_AW = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  input  word_t             csr_wdata,
  output logic [IDX_W-1:0]  cs_idx,
  output logic              cs_hi,
  output logic              wr_en,
  output word_t             wr_data,
  input  word_t             rd_word,
  output word_t             csr_rdata,
  output logic              csr_rvalid
);

  word_t rdata_d;
  word_t rdata_q;
  logic  rvalid_d;
  logic  rvalid_q;

  if (PAGE_CNT > 1) begin : g_idx
    assign cs_idx = csr_addr[CSR_AW-1:3];
  end else begin : g_noidx
    assign cs_idx = '0;
  end

  logic unused_csr;
  assign unused_csr = ^{csr_addr[1:0], csr_addr[CSR_AW-1]};

  assign cs_hi   = csr_addr[2];
  assign wr_en   = csr_wr;
  assign wr_data = csr_wdata;

  always_comb begin
    rvalid_d = csr_rd;
    rdata_d  = rdata_q;
    if (csr_rd) begin
      rdata_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign csr_rdata  = rdata_q;
  assign csr_rvalid = rvalid_q;

endmodule

// File: rtl/pax_xlate_dp.sv
module pax_xlate_dp import pax_pkg::*; #(
  parameter int PAGE_BITS = 12,
  parameter int PAGE_CNT  = 8,
  parameter int LOCAL_AW  = PAGE_BITS + sel_width(PAGE_CNT),
  localparam int IDX_W = idx_width(PAGE_CNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LOCAL_AW-1:0] req_addr,
  output logic [IDX_W-1:0]    lk_idx,
  input  entry_t              lk_entry,
  output logic                out_valid,
  output entry_t              out_addr
);

  entry_t splice;
  entry_t addr_d;
  entry_t addr_q;
  logic   valid_d;
  logic   valid_q;

  if (PAGE_CNT > 1) begin : g_sel
    assign lk_idx = req_addr[LOCAL_AW-1 -: IDX_W];
  end else begin : g_nosel
    assign lk_idx = '0;
  end

  logic unused_lo;
  assign unused_lo = ^lk_entry[PAGE_BITS-1:0];

  always_comb begin
    splice  = {lk_entry[ENTRY_W-1:PAGE_BITS], req_addr[PAGE_BITS-1:0]};
    valid_d = req_valid;
    addr_d  = addr_q;
    if (req_valid) begin
      addr_d = splice;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;

endmodule

// File: rtl/pcie_addr_xlate.sv
module pcie_addr_xlate import pax_pkg::*; #(
  parameter int PAGE_BITS = 12,
  parameter int PAGE_CNT  = 8,
  parameter bit DYNAMIC   = 1'b1,
  parameter logic [MAX_FIXED*ENTRY_W-1:0] FIXED_TABLE = '0,
  parameter int LOCAL_AW  = PAGE_BITS + sel_width(PAGE_CNT),
  parameter int CSR_AW    = idx_width(PAGE_CNT) + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LOCAL_AW-1:0] req_addr,
  output logic                out_valid,
  output logic [63:0]         out_addr,
  input  logic                csr_wr,
  input  logic                csr_rd,
  input  logic [CSR_AW-1:0]   csr_addr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  output logic                csr_rvalid
);

  localparam int IDX_W = idx_width(PAGE_CNT);

  logic             rst_sync_n;
  logic [IDX_W-1:0] lk_idx;
  entry_t           lk_entry;
  logic [IDX_W-1:0] cs_idx;
  logic             cs_hi;
  logic             wr_en;
  word_t            wr_data;
  word_t            rd_word;

  pax_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pax_csr #(.PAGE_CNT(PAGE_CNT)) u_csr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .csr_wr     (csr_wr),
    .csr_rd     (csr_rd),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .cs_idx     (cs_idx),
    .cs_hi      (cs_hi),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_word    (rd_word),
    .csr_rdata  (csr_rdata),
    .csr_rvalid (csr_rvalid)
  );

  pax_table #(
    .PAGE_CNT    (PAGE_CNT),
    .DYNAMIC     (DYNAMIC),
    .FIXED_TABLE (FIXED_TABLE)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_idx   (lk_idx),
    .lk_entry (lk_entry),
    .cs_idx   (cs_idx),
    .cs_hi    (cs_hi),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_word  (rd_word)
  );

  pax_xlate_dp #(
    .PAGE_BITS (PAGE_BITS),
    .PAGE_CNT  (PAGE_CNT),
    .LOCAL_AW  (LOCAL_AW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .lk_idx    (lk_idx),
    .lk_entry  (lk_entry),
    .out_valid (out_valid),
    .out_addr  (out_addr)
  );

endmodule

// File: rtl/pax_xlate_chk.sv
module pax_xlate_chk #(
  parameter int PAGE_BITS = 12,
  parameter int LOCAL_AW  = 15,
  parameter int CSR_AW    = 6,
  parameter bit DYNAMIC   = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [LOCAL_AW-1:0] req_addr,
  input logic                out_valid,
  input logic [63:0]         out_addr,
  input logic                csr_wr,
  input logic                csr_rd,
  input logic [CSR_AW-1:0]   csr_addr,
  input logic [31:0]         csr_wdata,
  input logic [31:0]         csr_rdata,
  input logic                csr_rvalid
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1) |-> (out_valid == $past(req_valid)));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && out_valid) |-> (out_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

  // R6
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1) |-> (csr_rvalid == $past(csr_rd)));

  // R6
  write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DYNAMIC && age_q >= 2'd2 && $past(csr_wr, 2) && $past(csr_rd) && !$past(csr_wr)
     && ($past(csr_addr[CSR_AW-1:2], 2) == $past(csr_addr[CSR_AW-1:2])))
    |-> (csr_rdata == $past(csr_wdata, 2)));

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && !$past(req_valid)) |-> $stable(out_addr));

endmodule

bind pcie_addr_xlate pax_xlate_chk #(
  .PAGE_BITS (PAGE_BITS),
  .LOCAL_AW  (LOCAL_AW),
  .CSR_AW    (CSR_AW),
  .DYNAMIC   (DYNAMIC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .csr_wr     (csr_wr),
  .csr_rd     (csr_rd),
  .csr_addr   (csr_addr),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .csr_rvalid (csr_rvalid)
);

// File: tb/pcie_addr_xlate_bench.sv
module pcie_addr_xlate_bench;

  localparam logic [63:0] F0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] F1 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] F2 = 64'h0000_00AB_0000_1111;
  localparam logic [63:0] F3 = 64'h8000_0000_FFFF_0000;
  localparam logic [1023:0] FTAB = {768'h0, F3, F2, F1, F0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  // software-loaded instance: 4 KB pages, 8 entries
  logic        req_valid = 1'b0;
  logic [14:0] req_addr = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        csr_wr = 1'b0;
  logic        csr_rd = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;

  // constant instance: 64 KB pages, 4 entries
  logic        f_req_valid = 1'b0;
  logic [17:0] f_req_addr = '0;
  logic        f_out_valid;
  logic [63:0] f_out_addr;
  logic        f_csr_wr = 1'b0;
  logic        f_csr_rd = 1'b0;
  logic [4:0]  f_csr_addr = '0;
  logic [31:0] f_csr_wdata = '0;
  logic [31:0] f_csr_rdata;
  logic        f_csr_rvalid;

  logic [63:0] shadow [8];
  logic [63:0] ftab [4];

  pcie_addr_xlate u_pcie_addr_xlate (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_addr (req_addr),
    .out_valid (out_valid), .out_addr (out_addr),
    .csr_wr (csr_wr), .csr_rd (csr_rd), .csr_addr (csr_addr),
    .csr_wdata (csr_wdata), .csr_rdata (csr_rdata), .csr_rvalid (csr_rvalid)
  );

  pcie_addr_xlate #(
    .PAGE_BITS (16), .PAGE_CNT (4), .DYNAMIC (1'b0), .FIXED_TABLE (FTAB)
  ) u_pcie_addr_xlate_fixed (
    .clk (clk), .rst_n (rst_n),
    .req_valid (f_req_valid), .req_addr (f_req_addr),
    .out_valid (f_out_valid), .out_addr (f_out_addr),
    .csr_wr (f_csr_wr), .csr_rd (f_csr_rd), .csr_addr (f_csr_addr),
    .csr_wdata (f_csr_wdata), .csr_rdata (f_csr_rdata), .csr_rvalid (f_csr_rvalid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dyn_exp(input logic [14:0] a);
    return {shadow[a[14:12]][63:12], a[11:0]};
  endfunction

  task automatic csr_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    check(req, {63'd0, csr_rvalid}, 64'd1);
    check(req, {32'd0, csr_rdata}, {32'd0, exp});
  endtask

  task automatic xlate(input string req, input logic [14:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, out_addr, dyn_exp(a));
  endtask

  task automatic t_reset;
    check("R7 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R7 csr_rvalid after reset", {63'd0, csr_rvalid}, 64'd0);
    for (int n = 0; n < 16; n++) begin
      csr_read("R7 entry word zero", 6'(n * 4), 32'h0);
    end
    xlate("R7 zero entry translation", 15'h5ABC);
  endtask

  task automatic t_csr_map;
    for (int n = 0; n < 8; n++) begin
      shadow[n] = {32'h1000_0000 + 32'(n), 32'hA000_0000 | 32'(n << 4) | 32'h0000_7000};
      csr_write(6'(n * 8), shadow[n][31:0]);
      csr_write(6'(n * 8 + 4), shadow[n][63:32]);
    end
    for (int n = 0; n < 8; n++) begin
      csr_read("R5 low word map", 6'(n * 8), shadow[n][31:0]);
      csr_read("R6 high word map", 6'(n * 8 + 4), shadow[n][63:32]);
    end
    // R5 byte bits 1:0 ignored: byte address 8*2+3 hits entry 2 low word
    shadow[2][31:0] = 32'h5555_AAAA;
    csr_write(6'd19, 32'h5555_AAAA);
    csr_read("R5 low bits ignored", 6'd16, 32'h5555_AAAA);
    csr_read("R5 high word untouched", 6'd22, shadow[2][63:32]);
  endtask

  task automatic t_translate;
    xlate("R3 first page zero offset", 15'h0000);
    xlate("R2 last page all-ones offset", 15'h7FFF);
    xlate("R3 middle page mixed offset", 15'h35A5);
    xlate("R2 page 6 offset msb", 15'h6800);
  endtask

  task automatic t_low_ignored;
    shadow[1][31:0] = 32'hFFFF_FFFF;
    csr_write(6'd8, 32'hFFFF_FFFF);
    xlate("R4 entry low bits not used", 15'h1123);
    check("R4 out low bits", {52'd0, out_addr[11:0]}, 64'h123);
    csr_read("R4 low bits read back", 6'd8, 32'hFFFF_FFFF);
  endtask

  task automatic t_stream;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 15'h2001;
    @(negedge clk);
    req_addr = 15'h4FFE;
    check("R1 first of pair valid", {63'd0, out_valid}, 64'd1);
    check("R1 first of pair addr", out_addr, dyn_exp(15'h2001));
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 second of pair valid", {63'd0, out_valid}, 64'd1);
    check("R1 second of pair addr", out_addr, dyn_exp(15'h4FFE));
    @(negedge clk);
    check("R1 valid drops when idle", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_same_cycle;
    logic [63:0] old_exp;
    old_exp = dyn_exp(15'h3456);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 15'h3456;
    csr_wr = 1'b1; csr_addr = 6'd28; csr_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0; csr_wr = 1'b0;
    check("R8 colliding request uses old entry", out_addr, old_exp);
    shadow[3][63:32] = 32'hDEAD_BEEF;
    xlate("R8 next request uses new entry", 15'h3456);
  endtask

  task automatic t_fixed;
    for (int n = 0; n < 4; n++) begin
      logic [17:0] a;
      a = {2'(n), 16'hC3A5 ^ 16'(n)};
      @(negedge clk);
      f_req_valid = 1'b1; f_req_addr = a;
      @(negedge clk);
      f_req_valid = 1'b0;
      check("R9 constant translation", f_out_addr, {ftab[n][63:16], a[15:0]});
    end
    @(negedge clk);
    f_csr_wr = 1'b1; f_csr_addr = 5'd0; f_csr_wdata = 32'h1234_5678;
    @(negedge clk);
    f_csr_addr = 5'd4;
    @(negedge clk);
    f_csr_wr = 1'b0; f_csr_rd = 1'b1; f_csr_addr = 5'd4;
    @(negedge clk);
    f_csr_rd = 1'b0;
    check("R9 high word write ignored", {32'd0, f_csr_rdata}, {32'd0, F0[63:32]});
    @(negedge clk);
    f_csr_rd = 1'b1; f_csr_addr = 5'd0;
    @(negedge clk);
    f_csr_rd = 1'b0;
    check("R9 low word write ignored", {32'd0, f_csr_rdata}, {32'd0, F0[31:0]});
    @(negedge clk);
    f_req_valid = 1'b1; f_req_addr = 18'h0_0042;
    @(negedge clk);
    f_req_valid = 1'b0;
    check("R9 translation after write attempt", f_out_addr, {F0[63:16], 16'h0042});
  endtask

  initial begin
    ftab[0] = F0; ftab[1] = F1; ftab[2] = F2; ftab[3] = F3;
    for (int n = 0; n < 8; n++) shadow[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_csr_map();
    t_translate();
    t_low_ignored();
    t_stream();
    t_same_cycle();
    t_fixed();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule